// File: doc/BRIEF.md
# Read-Sequence Write-Protect Detector

This block tracks the write-protect flag of a byte-wide flash device. The flag is not changed by any write command: it moves only when the host performs seven back-to-back read cycles at a fixed list of addresses. One list clears the flag and another sets it. The two lists share their first six addresses and differ only in the seventh.

The block watches the active-low read strobe and captures the read address when the strobe rises, which marks the end of the read. Only the low 16 address bits take part in the comparison. Data on the bus plays no part. Any write cycle drops whatever partial progress has been made. The flag comes up set after power-up reset. The command decoder of the device reads `prot_o` to decide whether erase or program commands may run.

`chg_o` pulses for one clock cycle in the cycle in which the flag takes its new value. A completed sequence that asks for the state already in force causes no pulse.

Top module: `rdseq_protect_det`

## Requirements
- R1: After reset, `prot_o` is 1 and `chg_o` is 0.
- R2: Seven read completions at low-16-bit addresses 1823h, 1820h, 1822h, 0418h, 041Bh, 0419h, 041Ah, in that order, clear `prot_o` on the clock edge that registers the seventh read.
- R3: The same first six addresses followed by 040Ah as the seventh set `prot_o` on the clock edge that registers the seventh read.
- R4: Address bits 18:16 are ignored when reads are matched.
- R5: A read that does not match the next expected address drops progress to zero, except that a read at 1823h always counts as the first step of a new attempt.
- R6: A cycle with `wr_n` low drops progress to zero and produces no flag change in that cycle. If `wr_n` is low in the same cycle as a read completion, the write wins.
- R7: A completed sequence that requests the state already in force leaves `prot_o` unchanged and gives no `chg_o` pulse.
- R8: A read completes only on a 0-to-1 transition of `rd_n`, and the address is sampled in the cycle in which `rd_n` is first seen high. A strobe held low or held high adds no further step.
- R9: `chg_o` is high for exactly one cycle, and only in the cycle in which `prot_o` differs from its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-up |
| rd_n | input | 1 | Active-low read strobe; its rising edge completes a read |
| wr_n | input | 1 | Active-low write strobe; low aborts any partial sequence |
| rd_addr | input | 19 | Read address; bits 15:0 are compared |
| prot_o | output | 1 | 1 = write-protected |
| chg_o | output | 1 | One-cycle pulse when `prot_o` changes |

## Verification
A wrong step counter is visible at the ports only when a seventh read completes. At that point `prot_o` either fails to move when it should, or moves when it should not, one clock after the strobe rises. For this reason the bench checks the flag and the pulse after every read and every write, not only at the end of each sequence. A stale strobe edge register shows up as a doubled or missing step. That error first appears as a wrong flag within the same seven-read window.

// File: rtl/rdseq_protect_pkg.sv
`timescale 1ns/1ps
package rdseq_protect_pkg;
    localparam int SEQ_LEN = 7;
    localparam int KEY_W   = 16;
    localparam int PROG_W  = $clog2(SEQ_LEN);
    // entries 0..5 are shared, 6 is the clearing tail, 7 the setting tail
    localparam int N_KEYS  = SEQ_LEN + 1;

    function automatic logic [KEY_W-1:0] step_key(input int idx);
        case (idx)
            0:       step_key = 16'h1823;
            1:       step_key = 16'h1820;
            2:       step_key = 16'h1822;
            3:       step_key = 16'h0418;
            4:       step_key = 16'h041B;
            5:       step_key = 16'h0419;
            6:       step_key = 16'h041A;
            default: step_key = 16'h040A;
        endcase
    endfunction

    typedef struct packed {
        logic [PROG_W-1:0] prog;
        logic              prot;
        logic              chg;
    } det_state_t;
endpackage

// File: rtl/rdseq_strobe_rise.sv
`timescale 1ns/1ps
module rdseq_strobe_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic strb_n,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = strb_n;
        rise   = strb_n & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/rdseq_key_match.sv
`timescale 1ns/1ps
module rdseq_key_match
    import rdseq_protect_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_KEYS-1:0] hit
);
    logic [KEY_W-1:0] key;
    logic unused_hi;

    assign key       = addr[KEY_W-1:0];
    assign unused_hi = ^addr[ADDR_W-1:KEY_W];

    for (genvar g = 0; g < N_KEYS; g++) begin : g_cmp
        assign hit[g] = (key == step_key(g));
    end
endmodule

// File: rtl/rdseq_protect_det.sv
`timescale 1ns/1ps
module rdseq_protect_det
    import rdseq_protect_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              prot_o,
    output logic              chg_o
);
    localparam logic [PROG_W-1:0] LAST = PROG_W'(SEQ_LEN - 1);

    logic              rd_done;
    logic [N_KEYS-1:0] hit;
    det_state_t        st_d, st_q;

    rdseq_strobe_rise u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .strb_n(rd_n),
        .rise  (rd_done)
    );

    rdseq_key_match #(.ADDR_W(ADDR_W)) u_match (
        .addr(rd_addr),
        .hit (hit)
    );

    always_comb begin
        logic restart;
        logic done;
        logic want;
        st_d     = st_q;
        st_d.chg = 1'b0;
        restart  = hit[0];
        done     = 1'b0;
        want     = st_q.prot;
        if (!wr_n) begin
            st_d.prog = '0;
        end else if (rd_done) begin
            if (st_q.prog == LAST) begin
                if (hit[SEQ_LEN - 1]) begin
                    done = 1'b1;
                    want = 1'b0;
                end else if (hit[SEQ_LEN]) begin
                    done = 1'b1;
                    want = 1'b1;
                end
                st_d.prog = restart ? PROG_W'(1) : '0;
                if (done && (want != st_q.prot)) begin
                    st_d.prot = want;
                    st_d.chg  = 1'b1;
                end
            end else if (hit[st_q.prog]) begin
                st_d.prog = st_q.prog + 1'b1;
            end else begin
                st_d.prog = restart ? PROG_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prog <= '0;
            st_q.prot <= 1'b1;
            st_q.chg  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_o = st_q.prot;
    assign chg_o  = st_q.chg;
endmodule

// File: rtl/rdseq_protect_det_chk.sv
`timescale 1ns/1ps
module rdseq_protect_det_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_n,
    input logic wr_n,
    input logic prot_o,
    input logic chg_o
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (prot_o && !chg_o));

    // R9
    flag_move_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && prot_o != $past(prot_o)) |-> chg_o);

    // R7
    pulse_real_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && chg_o) |-> (prot_o != $past(prot_o)));

    // R9
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_o |=> !chg_o);

    // R6
    write_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> !chg_o);

    // R8
    pulse_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && chg_o) |-> ($past(rd_n) && !$past(rd_n, 2)));
endmodule

bind rdseq_protect_det rdseq_protect_det_chk chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .prot_o(prot_o),
    .chg_o (chg_o)
);

// File: tb/rdseq_protect_det_tb_top.sv
`timescale 1ns/1ps
module rdseq_protect_det_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [18:0] rd_addr = '0;
    logic        prot_o, chg_o;

    int n_chk = 0;
    int n_fail = 0;
    bit ended = 0;

    int m_prog = 0;
    bit m_prot = 1;

    always #2.5 clk = ~clk;

    rdseq_protect_det dut_i (
        .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n),
        .rd_addr(rd_addr), .prot_o(prot_o), .chg_o(chg_o)
    );

    function automatic logic [15:0] seq_at(input int i);
        logic [15:0] t [8] = '{16'h1823, 16'h1820, 16'h1822, 16'h0418,
                               16'h041B, 16'h0419, 16'h041A, 16'h040A};
        return t[i];
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model step; returns expected pulse
    function automatic bit model_read(input logic [15:0] k);
        bit pulse = 0;
        bit done = 0;
        bit tgt = m_prot;
        if (m_prog == 6) begin
            if (k == 16'h041A) begin done = 1; tgt = 0; end
            else if (k == 16'h040A) begin done = 1; tgt = 1; end
            if (done && tgt != m_prot) begin m_prot = tgt; pulse = 1; end
            m_prog = (k == 16'h1823) ? 1 : 0;
        end else if (k == seq_at(m_prog)) begin
            m_prog++;
        end else begin
            m_prog = (k == 16'h1823) ? 1 : 0;
        end
        return pulse;
    endfunction

    task automatic do_read(input logic [18:0] a, input int low_cycles, input string tag);
        bit ep;
        @(negedge clk);
        check({tag, " R9 pulse cleared"}, chg_o, 0);
        rd_addr = a;
        rd_n = 1'b0;
        for (int i = 1; i < low_cycles; i++) begin
            @(negedge clk);
            check({tag, " R8 no step while low"}, chg_o, 0);
        end
        @(negedge clk);
        rd_n = 1'b1;
        ep = model_read(a[15:0]);
        @(negedge clk);
        check({tag, " flag"}, prot_o, m_prot);
        check({tag, " pulse"}, chg_o, ep);
    endtask

    task automatic do_write(input string tag);
        @(negedge clk);
        wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        m_prog = 0;
        check({tag, " R6 flag"}, prot_o, m_prot);
        check({tag, " R6 pulse"}, chg_o, 0);
    endtask

    task automatic run_seq(input bit lock, input logic [2:0] hi, input string tag);
        for (int i = 0; i < 7; i++) begin
            logic [15:0] k = (i == 6 && lock) ? seq_at(7) : seq_at(i);
            do_read({hi, k}, 1, tag);
        end
    endtask

    initial begin
        #(5.0 * 190000);
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R1 reset flag", prot_o, 1);
        check("R1 reset pulse", chg_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", prot_o, 1);

        run_seq(0, 3'd0, "R2 unlock");
        check("R2 cleared", prot_o, 0);
        run_seq(0, 3'd0, "R7 repeat unlock");
        run_seq(1, 3'd5, "R3 R4 lock high bits");
        check("R3 set", prot_o, 1);

        // R6: write mid-sequence, then the tail alone must do nothing
        for (int i = 0; i < 3; i++) do_read({3'd0, seq_at(i)}, 1, "R6 head");
        do_write("R6 abort");
        for (int i = 3; i < 7; i++) do_read({3'd0, seq_at(i)}, 1, "R6 tail");
        check("R6 still protected", prot_o, 1);

        // R5: restart on 1823 after a mismatch
        do_read({3'd0, 16'h1823}, 1, "R5");
        do_read({3'd0, 16'h1820}, 1, "R5");
        do_read({3'd0, 16'h1823}, 1, "R5 restart");
        for (int i = 1; i < 7; i++) do_read({3'd0, seq_at(i)}, 1, "R5 rest");
        check("R5 unlocked after restart", prot_o, 0);
        for (int i = 0; i < 4; i++) do_read({3'd0, seq_at(i)}, 1, "R5 head");
        do_read({3'd0, 16'h0419}, 1, "R5 wrong");
        for (int i = 5; i < 7; i++) do_read({3'd0, seq_at(i)}, 1, "R5 tail");
        do_read({3'd0, 16'h040A}, 1, "R5 tail");
        check("R5 mismatch kept state", prot_o, 0);

        // R8: long strobe on each step
        for (int i = 0; i < 7; i++) do_read({3'd0, (i == 6) ? seq_at(7) : seq_at(i)}, 3, "R8 long");
        check("R8 locked", prot_o, 1);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            int r = $urandom_range(99);
            logic [2:0] hi = 3'($urandom);
            if (r < 70) begin
                logic [15:0] k = (m_prog == 6) ? seq_at(6 + $urandom_range(1)) : seq_at(m_prog);
                do_read({hi, k}, 1 + $urandom_range(2), "R2 R3 rand");
            end else if (r < 80) do_read({hi, 16'h1823}, 1, "R5 rand");
            else if (r < 90) do_read(19'($urandom), 1, "R5 rand addr");
            else do_write("R6 rand");
        end

        ended = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule